// File: doc/BRIEF.md
# Fused multiply-add NaN result selector

This unit decides which NaN a single-precision fused multiply-add `(a*b)+c` returns when at least one operand is a NaN, or when the product is zero times infinity. It looks at the three operands, a flag from the multiplier that marks the zero-times-infinity product, a two-bit selection-policy input, the polarity of the quiet bit, and a default-result mode. It produces the result word, an invalid-operation flag and a two-bit code naming where the result came from. The multiply-add arithmetic itself is done elsewhere. This block only resolves the NaN case.

Four selection policies are offered. Each has its own priority among the operands and its own treatment of the zero-times-infinity product. An operand that is passed through is always made quiet first. The selection logic is combinational. Its outputs are registered once, so results appear one clock after the inputs.

Top module: `fma_nan_select`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. With `snan_msb_set_i`=0, a NaN is quiet when bit 22 is 1 and signaling otherwise. With `snan_msb_set_i`=1, a NaN is quiet when bit 22 is 0 and signaling when bit 22 is 1.
- R2: Policy 0 works as follows. If `infzero_i` is set and c is a quiet NaN, the result is the default NaN (code 3) and invalid is raised. Otherwise the first match wins, in this order: signaling c, signaling a, signaling b, quiet c, quiet a. If none match, b is chosen.
- R3: Policy 1 works as follows. If `infzero_i` is set, the result is always the default NaN (code 3) and invalid is raised. Otherwise the first match wins, in this order: signaling a, signaling b, signaling c, quiet a, quiet b. If none match, c is chosen.
- R4: Policy 2 works as follows. If `infzero_i` is set, invalid is raised and c is chosen (code 2). Otherwise a is chosen if it is any NaN, then c if it is any NaN. If neither is a NaN, b is chosen.
- R5: Policy 3 chooses a if it is a NaN, then b if it is a NaN, else c. `infzero_i` has no effect on the result or on invalid under this policy.
- R6: `invalid_o` is 1 whenever any of the three operands is a signaling NaN, under every policy.
- R7: A chosen operand that is signaling is made quiet before output. With `snan_msb_set_i`=0, bit 22 is set to 1. With `snan_msb_set_i`=1, it is replaced by the default NaN. A chosen quiet operand passes through unchanged.
- R8: The default NaN is 32'h7FC00000 when `snan_msb_set_i`=0 and 32'h7FBFFFFF when `snan_msb_set_i`=1. Code 3 always outputs it.
- R9: When `dflt_mode_i` is 1, the result word is the default NaN. The source code and invalid flag still report the normal selection.
- R10: Every output is registered, so it appears one clock after its inputs. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a_i | input | 32 | Multiplicand a |
| op_b_i | input | 32 | Multiplier b |
| op_c_i | input | 32 | Addend c |
| infzero_i | input | 1 | Product a*b was zero times infinity |
| policy_i | input | 2 | Selection policy 0..3 |
| snan_msb_set_i | input | 1 | 1 = a set fraction MSB marks a signaling NaN |
| dflt_mode_i | input | 1 | Force the default NaN on the result word |
| result_o | output | 32 | Selected NaN word |
| invalid_o | output | 1 | Invalid-operation flag |
| src_code_o | output | 2 | 0=a, 1=b, 2=c, 3=default NaN |

## Verification
The quiet-output assertion assumes one thing when `infzero_i` is clear: at least one operand is a NaN. That is the only situation in which the unit is consulted. Under that assumption, the chosen word is always a NaN, and with the normal polarity it carries bit 22. The directed vectors and the random pool both keep to this condition by always placing a NaN in at least one operand. The pool also mixes in ordinary numbers and infinities, so that the per-operand priorities are still exercised. The infzero flag is raised on random vectors as well, which may pair it with a non-NaN c. The assertions that check it look only at the code and the invalid flag, never at the word's class.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_B    = 2'd1,
        SRC_C    = 2'd2,
        SRC_DFLT = 2'd3
    } src_code_e;

    typedef enum logic [1:0] {
        POL_C_FIRST   = 2'd0,
        POL_SIG_ABC   = 2'd1,
        POL_A_C_B     = 2'd2,
        POL_PLAIN_ABC = 2'd3
    } policy_e;

    localparam int NUM_OPS = 3;

endpackage

// File: rtl/fma_nan_classify.sv
module fma_nan_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word_i,
    input  logic                 snan_msb_set_i,
    output logic                 is_nan_o,
    output logic                 is_quiet_o,
    output logic                 is_sig_o
);
    localparam int TOP_MAN = MAN_W - 1;

    logic exp_full;
    logic man_nz;

    always_comb begin
        exp_full   = &word_i[EXP_W+MAN_W-1:MAN_W];
        man_nz     = |word_i[MAN_W-1:0];
        is_nan_o   = exp_full && man_nz;
        is_quiet_o = is_nan_o && (word_i[TOP_MAN] ^ snan_msb_set_i);
        is_sig_o   = is_nan_o && !(word_i[TOP_MAN] ^ snan_msb_set_i);
    end

endmodule

// File: rtl/fma_nan_quieten.sv
module fma_nan_quieten #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word_i,
    input  logic                 is_sig_i,
    input  logic                 snan_msb_set_i,
    input  logic [EXP_W+MAN_W:0] dflt_i,
    output logic [EXP_W+MAN_W:0] word_o
);
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (MAN_W - 1);

    always_comb begin
        if (!is_sig_i) begin
            word_o = word_i;
        end else if (snan_msb_set_i) begin
            word_o = dflt_i;
        end else begin
            word_o = word_i | QUIET_BIT;
        end
    end

endmodule

// File: rtl/fma_nan_priority.sv
module fma_nan_priority
    import fma_nan_pkg::*;
(
    input  logic [NUM_OPS-1:0] quiet_i,
    input  logic [NUM_OPS-1:0] sig_i,
    input  logic               infzero_i,
    input  logic [1:0]         policy_i,
    output src_code_e          code_o,
    output logic               iz_invalid_o
);
    logic [NUM_OPS-1:0] any_nan;

    always_comb begin
        any_nan      = quiet_i | sig_i;
        code_o       = SRC_B;
        iz_invalid_o = 1'b0;
        unique case (policy_e'(policy_i))
            POL_C_FIRST: begin
                if (infzero_i && quiet_i[2]) begin
                    iz_invalid_o = 1'b1;
                    code_o       = SRC_DFLT;
                end else if (sig_i[2])   code_o = SRC_C;
                else if (sig_i[0])       code_o = SRC_A;
                else if (sig_i[1])       code_o = SRC_B;
                else if (quiet_i[2])     code_o = SRC_C;
                else if (quiet_i[0])     code_o = SRC_A;
                else                     code_o = SRC_B;
            end
            POL_SIG_ABC: begin
                if (infzero_i) begin
                    iz_invalid_o = 1'b1;
                    code_o       = SRC_DFLT;
                end else if (sig_i[0])   code_o = SRC_A;
                else if (sig_i[1])       code_o = SRC_B;
                else if (sig_i[2])       code_o = SRC_C;
                else if (quiet_i[0])     code_o = SRC_A;
                else if (quiet_i[1])     code_o = SRC_B;
                else                     code_o = SRC_C;
            end
            POL_A_C_B: begin
                if (infzero_i) begin
                    iz_invalid_o = 1'b1;
                    code_o       = SRC_C;
                end else if (any_nan[0]) code_o = SRC_A;
                else if (any_nan[2])     code_o = SRC_C;
                else                     code_o = SRC_B;
            end
            default: begin
                if (any_nan[0])          code_o = SRC_A;
                else if (any_nan[1])     code_o = SRC_B;
                else                     code_o = SRC_C;
            end
        endcase
    end

endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
    import fma_nan_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [EXP_W+MAN_W:0]      op_a_i,
    input  logic [EXP_W+MAN_W:0]      op_b_i,
    input  logic [EXP_W+MAN_W:0]      op_c_i,
    input  logic                      infzero_i,
    input  logic [1:0]                policy_i,
    input  logic                      snan_msb_set_i,
    input  logic                      dflt_mode_i,
    output logic [EXP_W+MAN_W:0]      result_o,
    output logic                      invalid_o,
    output logic [1:0]                src_code_o
);
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam logic [WORD_W-1:0] DFLT_NORM =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] DFLT_INV =
        {1'b0, {EXP_W{1'b1}}, 1'b0, {(MAN_W-1){1'b1}}};

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              inv;
        logic [1:0]        code;
    } out_t;

    out_t state_d;
    out_t state_q;

    logic [WORD_W-1:0] ops      [NUM_OPS];
    logic [WORD_W-1:0] quieted  [NUM_OPS];
    logic [NUM_OPS-1:0] nan_vec;
    logic [NUM_OPS-1:0] quiet_vec;
    logic [NUM_OPS-1:0] sig_vec;
    logic [WORD_W-1:0]  dflt_word;
    src_code_e          pick_code;
    logic               iz_invalid;

    always_comb begin
        ops[0]    = op_a_i;
        ops[1]    = op_b_i;
        ops[2]    = op_c_i;
        dflt_word = snan_msb_set_i ? DFLT_INV : DFLT_NORM;
    end

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
        fma_nan_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .word_i        (ops[gi]),
            .snan_msb_set_i(snan_msb_set_i),
            .is_nan_o      (nan_vec[gi]),
            .is_quiet_o    (quiet_vec[gi]),
            .is_sig_o      (sig_vec[gi])
        );
        fma_nan_quieten #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_qt (
            .word_i        (ops[gi]),
            .is_sig_i      (sig_vec[gi]),
            .snan_msb_set_i(snan_msb_set_i),
            .dflt_i        (dflt_word),
            .word_o        (quieted[gi])
        );
    end

    fma_nan_priority u_prio (
        .quiet_i     (quiet_vec),
        .sig_i       (sig_vec),
        .infzero_i   (infzero_i),
        .policy_i    (policy_i),
        .code_o      (pick_code),
        .iz_invalid_o(iz_invalid)
    );

    always_comb begin
        state_d.code = pick_code;
        state_d.inv  = (|sig_vec) | iz_invalid;
        if (dflt_mode_i) begin
            state_d.word = dflt_word;
        end else begin
            unique case (pick_code)
                SRC_A:   state_d.word = quieted[0];
                SRC_B:   state_d.word = quieted[1];
                SRC_C:   state_d.word = quieted[2];
                default: state_d.word = dflt_word;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o   = state_q.word;
    assign invalid_o  = state_q.inv;
    assign src_code_o = state_q.code;

    AST_SIG_RAISES_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (|sig_vec) |=> invalid_o); // R6
    AST_DFLT_MODE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_mode_i |=> (result_o == $past(dflt_word))); // R9
    AST_CODE3_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_code == SRC_DFLT) |=> (result_o == $past(dflt_word) && src_code_o == 2'd3)); // R8
    AST_P1_INFZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd1 && infzero_i) |=> (src_code_o == 2'd3 && invalid_o)); // R3
    AST_P2_INFZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd2 && infzero_i) |=> (src_code_o == 2'd2 && invalid_o)); // R4
    AST_P3_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd3 && sig_vec == '0) |=> !invalid_o); // R5
    AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!snan_msb_set_i && (|nan_vec) && !infzero_i) |=> result_o[MAN_W-1]); // R7

endmodule

// File: tb/fma_nan_select_tb.sv
module fma_nan_select_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        infzero = 1'b0;
    logic [1:0]  policy = '0;
    logic        pol = 1'b0;
    logic        dmode = 1'b0;
    logic [31:0] result;
    logic        invalid;
    logic [1:0]  code;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    fma_nan_select u_dut (
        .clk(clk), .rst_n(rst_n),
        .op_a_i(op_a), .op_b_i(op_b), .op_c_i(op_c),
        .infzero_i(infzero), .policy_i(policy),
        .snan_msb_set_i(pol), .dflt_mode_i(dmode),
        .result_o(result), .invalid_o(invalid), .src_code_o(code)
    );

    function automatic bit is_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic bit is_q(logic [31:0] x, bit p);
        return is_nan(x) && (p ? !x[22] : x[22]);
    endfunction
    function automatic bit is_s(logic [31:0] x, bit p);
        return is_nan(x) && !is_q(x, p);
    endfunction

    // returns {invalid, code, word}
    function automatic logic [34:0] model(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                                          bit iz, int pl, bit p, bit dm);
        logic [31:0] dn = p ? 32'h7FBFFFFF : 32'h7FC00000;
        logic [31:0] src;
        logic [31:0] w;
        int which;
        bit inv = is_s(a, p) || is_s(b, p) || is_s(c, p);
        bit aq = is_q(a, p), as = is_s(a, p), bq = is_q(b, p), bs = is_s(b, p);
        bit cq = is_q(c, p), cs = is_s(c, p);
        if (pl == 0) begin
            if (iz && cq) begin inv = 1; which = 3; end
            else which = cs ? 2 : as ? 0 : bs ? 1 : cq ? 2 : aq ? 0 : 1;
        end else if (pl == 1) begin
            if (iz) begin inv = 1; which = 3; end
            else which = as ? 0 : bs ? 1 : cs ? 2 : aq ? 0 : bq ? 1 : 2;
        end else if (pl == 2) begin
            if (iz) begin inv = 1; which = 2; end
            else which = is_nan(a) ? 0 : is_nan(c) ? 2 : 1;
        end else begin
            which = is_nan(a) ? 0 : is_nan(b) ? 1 : 2;
        end
        src = (which == 0) ? a : (which == 1) ? b : c;
        if (dm || which == 3) w = dn;
        else if (is_s(src, p)) w = p ? dn : (src | 32'h0040_0000);
        else w = src;
        return {inv, 2'(which), w};
    endfunction

    task automatic check(string tag, logic [34:0] exp);
        vectors++;
        if ({invalid, code, result} !== exp) begin
            miscompares++;
            $display("FAIL %s: got inv=%0b code=%0d word=%h expected inv=%0b code=%0d word=%h",
                     tag, invalid, code, result, exp[34], exp[33:32], exp[31:0]);
        end
    endtask

    task automatic apply(string tag, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                         bit iz, int pl, bit p, bit dm);
        logic [34:0] exp;
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; infzero = iz;
        policy = 2'(pl); pol = p; dmode = dm;
        exp = model(a, b, c, iz, pl, p, dm);
        @(negedge clk);
        check(tag, exp);
    endtask

    localparam logic [31:0] QN  = 32'h7FC0_0011; // quiet when pol=0, signaling when pol=1
    localparam logic [31:0] SN  = 32'h7F80_0005; // signaling when pol=0, quiet when pol=1
    localparam logic [31:0] QN2 = 32'hFFC0_0300;
    localparam logic [31:0] SN2 = 32'hFF81_0000;
    localparam logic [31:0] ONE = 32'h3F80_0000;
    localparam logic [31:0] INF = 32'h7F80_0000;
    localparam logic [31:0] ZRO = 32'h0000_0000;

    function automatic logic [31:0] pick_pool(int k);
        case (k)
            0: return QN;  1: return SN;  2: return QN2; 3: return SN2;
            4: return ONE; 5: return INF; 6: return ZRO;
            default: return {1'b0, 8'hFF, 23'($urandom) | 23'd1};
        endcase
    endfunction

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset", 35'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 classification under both polarities (policy 3: a NaN picked)
        apply("R1 quiet a pol0", QN, ONE, ONE, 0, 3, 0, 0);
        apply("R1 sig a pol1", QN, ONE, ONE, 0, 3, 1, 0);
        apply("R1 inf not NaN", INF, QN2, ONE, 0, 3, 0, 0);
        // R2 policy 0
        apply("R2 c sig first", SN, SN2, SN, 0, 0, 0, 0);
        apply("R2 a sig over c quiet", SN, QN, QN2, 0, 0, 0, 0);
        apply("R2 c quiet over a quiet", QN, ONE, QN2, 0, 0, 0, 0);
        apply("R2 infzero c quiet", ZRO, INF, QN, 1, 0, 0, 0);
        apply("R2 infzero c sig", ZRO, INF, SN, 1, 0, 0, 0);
        // R3 policy 1
        apply("R3 b sig over a quiet", QN, SN, SN2, 0, 1, 0, 0);
        apply("R3 else c", ONE, ONE, QN, 0, 1, 0, 0);
        apply("R3 infzero", ZRO, INF, QN, 1, 1, 0, 0);
        // R4 policy 2
        apply("R4 a any", SN, QN, QN2, 0, 2, 0, 0);
        apply("R4 c over b", ONE, QN, QN2, 0, 2, 0, 0);
        apply("R4 infzero keeps c", ZRO, INF, QN, 1, 2, 0, 0);
        // R5 policy 3 ignores infzero
        apply("R5 infzero ignored", ZRO, INF, QN, 1, 3, 0, 0);
        apply("R5 b then", ONE, QN2, SN, 0, 3, 0, 0);
        // R6 invalid from unchosen operand
        apply("R6 sig b unchosen", QN, SN, ONE, 0, 3, 0, 0);
        // R7 quieting
        apply("R7 sig chosen pol0", SN2, ONE, ONE, 0, 3, 0, 0);
        apply("R7 sig chosen pol1", QN, ONE, ONE, 0, 3, 1, 0);
        // R8 default values
        apply("R8 default pol1", ZRO, INF, SN, 1, 1, 1, 0);
        // R9 default mode
        apply("R9 dflt mode pol0", QN2, SN, ONE, 0, 2, 0, 1);
        apply("R9 dflt mode pol1", SN, SN, ONE, 0, 0, 1, 1);
        if (result !== 32'h7FBFFFFF) begin
            miscompares++;
            $display("FAIL R8: got %h expected 7fbfffff", result);
        end
        vectors++;

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b, c;
            int pl;
            string tag;
            a = pick_pool($urandom_range(0, 7));
            b = pick_pool($urandom_range(0, 7));
            c = pick_pool($urandom_range(0, 7));
            if (!is_nan(a) && !is_nan(b) && !is_nan(c)) c = QN2;
            pl = $urandom_range(0, 3);
            tag = (pl == 0) ? "R2 random" : (pl == 1) ? "R3 random" :
                  (pl == 2) ? "R4 random" : "R5 random";
            apply(tag, a, b, c, ($urandom_range(0, 3) == 0), pl,
                  1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule